// File: doc/BRIEF.md
# Hash Accelerator Register Front-End

This block sits between a 32-bit register bus and a SHA-1/SHA-256 compression engine. Software, or a DMA channel writing the same bus, fills sixteen message words. A block then goes to the engine as one 512-bit word together with a first-block flag and an algorithm select. The engine's result is captured and can be read back as five or eight digest words.

Blocks can be launched in two ways. In manual feed mode only a start command launches a block. In the automatic and DMA-fed modes, writing the last message word launches it. A first-block command makes the next launched block restart from the initial hash constants. Blocks launched without it continue from the previous digest. The block also keeps a maskable interrupt status. This status records data ready, an empty transmit buffer and illegal register accesses, each illegal access with an encoded reason. A software reset command returns everything to the power-up state.

Top module: `hash_regfront`

## Requirements
- R1: After reset the mode register (0x04), interrupt mask (0x18) and status (0x1C) all read 0, and blk_valid_o and irq_o are low.
- R2: In manual feed mode (mode bits [1:0]=0), writing 1 to control bit 0 (0x00) while idle makes blk_valid_o high for exactly one cycle, in the cycle after the write. blk_data_o bits [32n+31:32n] then hold the word written at 0x40+4n, and algo_o equals mode bit 8. Writing the word at 0x7C does not launch a block in this mode. A start issued while a block is in flight is ignored.
- R3: In automatic (mode 1) and DMA-fed (mode 2) feed, writing offset 0x7C launches a block. Writing any other message word does not.
- R4: Writing control bit 4 makes the next launched block carry blk_first_o=1, whether bit 4 comes with the start or in an earlier write. Later launches without it carry blk_first_o=0.
- R5: When the engine reports done, its digest is captured. Offset 0x80+4n reads bits [32n+31:32n] of that digest. With SHA-1 selected (mode bit 8 = 0), words 5 to 7 read 0. With SHA-256 selected, all eight words are valid.
- R6: Status bit 0 (data ready) is set when the engine reports done and is cleared when the next block is launched.
- R7: Writing a 1 to 0x10 sets the mask bit at that position, and writing a 1 to 0x14 clears it. Only bits 0, 1, 2 and 8 exist. 0x18 reads back the mask.
- R8: irq_o is high exactly when some status bit and the mask bit at the same position are both 1.
- R9: An illegal access sets status bit 8 and records a code in status bits [14:12]. The codes are: 0 for a message word written while busy (the write is dropped), 1 for a digest read while busy, 2 for a mode write while busy (the write is dropped), and 5 for a write to 0x18, 0x1C or the digest area. The first violation is held until the status register is read. That read returns it and clears it.
- R10: Status bit 2 is set when a block is launched in DMA-fed mode and is cleared by the next accepted message word write.
- R11: Writing control bit 8 clears the mode, mask, status, message words, digest, pending first flag and busy state.
- R12: Mode bits 3 and 4 are stored and read back without affecting behaviour. Mode bits other than 0, 1, 3, 4 and 8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as rd_en_i |
| blk_valid_o | output | 1 | One-cycle block launch to the engine |
| blk_first_o | output | 1 | Launched block starts a new message |
| algo_o | output | 1 | 1 selects SHA-256, 0 selects SHA-1 |
| blk_data_o | output | 512 | Message block, word n in bits [32n+31:32n] |
| eng_done_i | input | 1 | Engine finished the block |
| eng_digest_i | input | 256 | Engine result, word n in bits [32n+31:32n] |
| irq_o | output | 1 | Interrupt request |

## Verification
A stuck or lost busy state shows up within one bus access. A start during a block leaks a second blk_valid_o pulse. A block that never completes leaves data ready low and keeps raising violation codes. A wrong message word index or a wrong digest word index shows up in the first launched block or the first digest read, because every word carries a distinct value. A violation latch that is overwritten or cleared too early is seen on the very next status read. A mask or status bit that is wrong shows on irq_o in the same cycle.

// File: rtl/hash_regfront_pkg.sv
package hash_regfront_pkg;
  typedef enum logic [1:0] {
    FEED_MANUAL = 2'd0,
    FEED_AUTO   = 2'd1,
    FEED_DMA    = 2'd2,
    FEED_RSVD   = 2'd3
  } feed_e;

  typedef enum logic [2:0] {
    VIOL_DIN_WR  = 3'd0,
    VIOL_DOUT_RD = 3'd1,
    VIOL_MODE_WR = 3'd2,
    VIOL_RO_WR   = 3'd5
  } viol_e;

  localparam int unsigned BIT_DRDY  = 0;
  localparam int unsigned BIT_ENDTX = 1;
  localparam int unsigned BIT_TXE   = 2;
  localparam int unsigned BIT_VIOL  = 8;
  localparam logic [31:0] MASK_IMPL = 32'h0000_0107;
endpackage

// File: rtl/hash_msg_buffer.sv
module hash_msg_buffer #(
  parameter int unsigned WORDS = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [WORDS*DW-1:0] blk_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   word_q <= '0;
      else if (clr_i)                                word_q <= '0;
      else if (we_i && idx_i == IDX_W'(g))           word_q <= wdata_i;
    end
    assign blk_o[g*DW +: DW] = word_q;
  end

  AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !clr_i) |=> $stable(blk_o)); // R2
endmodule

// File: rtl/hash_digest_store.sv
module hash_digest_store #(
  parameter int unsigned WORDS    = 8,
  parameter int unsigned DW       = 32,
  parameter int unsigned SHORT_WD = 5,
  localparam int unsigned IDX_W   = $clog2(WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                cap_i,
  input  logic                long_i,
  input  logic [WORDS*DW-1:0] din_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [DW-1:0]       rdata_o
);
  logic [WORDS*DW-1:0] dig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dig_q <= '0;
    else if (clr_i)  dig_q <= '0;
    else if (cap_i)  dig_q <= din_i;
  end

  logic [DW-1:0] words [WORDS];
  for (genvar g = 0; g < WORDS; g++) begin : g_rd
    assign words[g] = dig_q[g*DW +: DW];
  end

  always_comb begin
    rdata_o = words[idx_i];
    if (!long_i && int'(idx_i) >= SHORT_WD) rdata_o = '0;
  end

  AST_DIGEST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !clr_i) |=> $stable(dig_q)); // R5
endmodule

// File: rtl/hash_irq_ctrl.sv
module hash_irq_ctrl
  import hash_regfront_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          mask_set_i,
  input  logic          mask_clr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          drdy_set_i,
  input  logic          drdy_clr_i,
  input  logic          txe_set_i,
  input  logic          txe_clr_i,
  input  logic          viol_i,
  input  viol_e         viol_type_i,
  input  logic          stat_rd_i,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] mask_o,
  output logic          irq_o
);
  logic [DW-1:0] mask_q;
  logic          drdy_q, txe_q, viol_q;
  logic [2:0]    vtype_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0; drdy_q <= 1'b0; txe_q <= 1'b0; viol_q <= 1'b0; vtype_q <= '0;
    end else if (clr_i) begin
      mask_q <= '0; drdy_q <= 1'b0; txe_q <= 1'b0; viol_q <= 1'b0; vtype_q <= '0;
    end else begin
      if (mask_set_i)      mask_q <= mask_q | (wdata_i & DW'(MASK_IMPL));
      else if (mask_clr_i) mask_q <= mask_q & ~wdata_i;
      if (drdy_set_i)      drdy_q <= 1'b1;
      else if (drdy_clr_i) drdy_q <= 1'b0;
      if (txe_set_i)       txe_q  <= 1'b1;
      else if (txe_clr_i)  txe_q  <= 1'b0;
      if (stat_rd_i) begin
        viol_q  <= 1'b0;
        vtype_q <= '0;
      end else if (viol_i && !viol_q) begin
        viol_q  <= 1'b1;
        vtype_q <= viol_type_i;
      end
    end
  end

  always_comb begin
    status_o            = '0;
    status_o[BIT_DRDY]  = drdy_q;
    status_o[BIT_ENDTX] = 1'b0;
    status_o[BIT_TXE]   = txe_q;
    status_o[BIT_VIOL]  = viol_q;
    status_o[14:12]     = vtype_q;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(status_o & mask_q);

  AST_VIOL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_q && !stat_rd_i && !clr_i) |=> viol_q); // R9
  AST_VTYPE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_q && !stat_rd_i && !clr_i) |=> $stable(vtype_q)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0)); // R8
endmodule

// File: rtl/hash_regfront.sv
module hash_regfront
  import hash_regfront_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DW       = 32,
  parameter int unsigned IN_WORDS = 16,
  parameter int unsigned DG_WORDS = 8,
  parameter int unsigned SHORT_WD = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   blk_valid_o,
  output logic                   blk_first_o,
  output logic                   algo_o,
  output logic [IN_WORDS*DW-1:0] blk_data_o,
  input  logic                   eng_done_i,
  input  logic [DG_WORDS*DW-1:0] eng_digest_i,
  output logic                   irq_o
);
  localparam int unsigned IDX_W  = $clog2(IN_WORDS);
  localparam int unsigned DIDX_W = $clog2(DG_WORDS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_IDIS = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_IMSK = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_ISTA = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(8'h80);
  localparam int unsigned DIN_SPAN  = IN_WORDS * 4;
  localparam int unsigned DOUT_SPAN = DG_WORDS * 4;

  logic aligned, is_ctrl, is_mode, is_ien, is_idis, is_imsk, is_ista, is_din, is_dout;
  logic [ADDR_W-1:0] off_din, off_dout;
  logic [IDX_W-1:0]  din_idx;
  logic [DIDX_W-1:0] dout_idx;

  assign aligned  = addr_i[1:0] == 2'b00;
  assign off_din  = addr_i - A_DIN;
  assign off_dout = addr_i - A_DOUT;
  assign din_idx  = off_din[IDX_W+1:2];
  assign dout_idx = off_dout[DIDX_W+1:2];
  assign is_ctrl  = addr_i == A_CTRL;
  assign is_mode  = addr_i == A_MODE;
  assign is_ien   = addr_i == A_IEN;
  assign is_idis  = addr_i == A_IDIS;
  assign is_imsk  = addr_i == A_IMSK;
  assign is_ista  = addr_i == A_ISTA;
  assign is_din   = aligned && addr_i >= A_DIN  && int'(off_din)  < DIN_SPAN;
  assign is_dout  = aligned && addr_i >= A_DOUT && int'(off_dout) < DOUT_SPAN;

  // mode and sequencing state
  feed_e feed_q;
  logic  dual_q, dly_q, algo_q;
  logic  busy_q, valid_q, first_q, pend_first_q;

  logic wr_ctrl, swrst, din_wr_ok, launch_man, launch_auto, launch, first_now;
  logic viol_din, viol_dout, viol_mode, viol_ro, viol_any;
  viol_e viol_type;

  assign wr_ctrl     = wr_en_i && is_ctrl;
  assign swrst       = wr_ctrl && wdata_i[8];
  assign din_wr_ok   = wr_en_i && is_din && !busy_q;
  assign launch_man  = wr_ctrl && wdata_i[0] && !wdata_i[8] && !busy_q;
  assign launch_auto = din_wr_ok && din_idx == IDX_W'(IN_WORDS - 1)
                       && (feed_q == FEED_AUTO || feed_q == FEED_DMA);
  assign launch      = launch_man || launch_auto;
  assign first_now   = pend_first_q || (wr_ctrl && wdata_i[4]);

  assign viol_din  = wr_en_i && is_din && busy_q;
  assign viol_dout = rd_en_i && is_dout && busy_q;
  assign viol_mode = wr_en_i && is_mode && busy_q;
  assign viol_ro   = wr_en_i && (is_imsk || is_ista || is_dout);
  assign viol_any  = viol_din || viol_dout || viol_mode || viol_ro;

  always_comb begin
    if (viol_din)       viol_type = VIOL_DIN_WR;
    else if (viol_dout) viol_type = VIOL_DOUT_RD;
    else if (viol_mode) viol_type = VIOL_MODE_WR;
    else                viol_type = VIOL_RO_WR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || swrst) begin
      feed_q <= FEED_MANUAL; dual_q <= 1'b0; dly_q <= 1'b0; algo_q <= 1'b0;
      busy_q <= 1'b0; valid_q <= 1'b0; first_q <= 1'b0; pend_first_q <= 1'b0;
    end else begin
      valid_q <= launch;
      if (launch) begin
        busy_q       <= 1'b1;
        first_q      <= first_now;
        pend_first_q <= 1'b0;
      end else begin
        if (wr_ctrl && wdata_i[4]) pend_first_q <= 1'b1;
        if (eng_done_i)            busy_q       <= 1'b0;
      end
      if (wr_en_i && is_mode && !busy_q) begin
        feed_q <= feed_e'(wdata_i[1:0]);
        dual_q <= wdata_i[3];
        dly_q  <= wdata_i[4];
        algo_q <= wdata_i[8];
      end
    end
  end

  logic [DW-1:0] status_w, mask_w, dig_rd;
  logic          cap;
  assign cap = eng_done_i && busy_q;

  hash_msg_buffer #(.WORDS(IN_WORDS), .DW(DW)) u_msg (
    .clk_i, .rst_ni, .clr_i(swrst), .we_i(din_wr_ok), .idx_i(din_idx),
    .wdata_i, .blk_o(blk_data_o)
  );

  hash_digest_store #(.WORDS(DG_WORDS), .DW(DW), .SHORT_WD(SHORT_WD)) u_dig (
    .clk_i, .rst_ni, .clr_i(swrst), .cap_i(cap), .long_i(algo_q),
    .din_i(eng_digest_i), .idx_i(dout_idx), .rdata_o(dig_rd)
  );

  hash_irq_ctrl #(.DW(DW)) u_irq (
    .clk_i, .rst_ni, .clr_i(swrst),
    .mask_set_i(wr_en_i && is_ien), .mask_clr_i(wr_en_i && is_idis), .wdata_i,
    .drdy_set_i(cap), .drdy_clr_i(launch),
    .txe_set_i(launch && feed_q == FEED_DMA), .txe_clr_i(din_wr_ok),
    .viol_i(viol_any && !swrst), .viol_type_i(viol_type),
    .stat_rd_i(rd_en_i && is_ista),
    .status_o(status_w), .mask_o(mask_w), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (is_mode) begin
        rdata_o[1:0] = feed_q;
        rdata_o[3]   = dual_q;
        rdata_o[4]   = dly_q;
        rdata_o[8]   = algo_q;
      end
      else if (is_imsk) rdata_o = mask_w;
      else if (is_ista) rdata_o = status_w;
      else if (is_dout) rdata_o = dig_rd;
    end
  end

  assign blk_valid_o = valid_q;
  assign blk_first_o = first_q;
  assign algo_o      = algo_q;

  AST_LAUNCH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o |=> !blk_valid_o); // R2
  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !eng_done_i && !swrst) |=> !blk_valid_o); // R2
  AST_DRDY_LOW_ON_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o |-> !status_w[BIT_DRDY]); // R6
endmodule

// File: tb/hash_regfront_tb_top.sv
`timescale 1ns/1ps
module hash_regfront_tb_top;
  localparam int LAT = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         blk_valid, blk_first, algo, irq;
  logic [511:0] blk_data;
  logic         eng_done;
  logic [255:0] eng_digest;

  int errors = 0, checks = 0, launches = 0;
  bit finished = 0;
  logic [31:0] cur [16];

  always #5 clk = ~clk;

  hash_regfront dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .blk_valid_o(blk_valid), .blk_first_o(blk_first),
    .algo_o(algo), .blk_data_o(blk_data), .eng_done_i(eng_done),
    .eng_digest_i(eng_digest), .irq_o(irq)
  );

  // engine responder
  int           cnt;
  logic [511:0] cap_blk;
  logic         cap_first, cap_algo;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= 0; eng_done <= 1'b0; eng_digest <= '0;
      cap_blk <= '0; cap_first <= 1'b0; cap_algo <= 1'b0;
    end else begin
      eng_done <= 1'b0;
      if (blk_valid) begin
        launches <= launches + 1;
        cnt <= LAT; cap_blk <= blk_data; cap_first <= blk_first; cap_algo <= algo;
      end else if (cnt != 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) begin
          eng_done <= 1'b1;
          for (int k = 0; k < 8; k++)
            eng_digest[32*k +: 32] <= exp_dig(k, cap_blk[32*k +: 32], cap_first, cap_algo);
        end
      end
    end
  end

  function automatic logic [31:0] exp_dig(int k, logic [31:0] w, logic f, logic a);
    return w ^ (f ? 32'hA5A5_0000 : 32'h0) ^ (a ? 32'h0000_0100 : 32'h0) ^ (32'(k) << 24);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr_word(int n, logic [31:0] d);
    wr(8'h40 + 8'(4*n), d);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R1 watchdog act=0 exp=1");
      report();
    end
  end

  initial begin : main
    logic [31:0] r;
    int base;
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(8'h04, r); chk("R1 mode", r, 0);
    rd(8'h18, r); chk("R1 mask", r, 0);
    rd(8'h1C, r); chk("R1 status", r, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 valid", 32'(blk_valid), 0);

    // R2 manual feed, SHA-1
    wr(8'h04, 32'h0);
    base = launches;
    for (int n = 0; n < 16; n++) begin
      cur[n] = 32'h1000_0000 + 32'(n) * 32'h0101_0011;
      wr_word(n, cur[n]);
    end
    idle(2);
    chk("R2 no launch on last word in manual", 32'(launches), 32'(base));
    wr(8'h00, 32'h11);
    chk("R2 valid after start", 32'(blk_valid), 1);
    chk("R4 first with start", 32'(blk_first), 1);
    chk("R2 algo sha1", 32'(algo), 0);
    for (int n = 0; n < 16; n++) chk("R2 block word", blk_data[32*n +: 32], cur[n]);
    idle(1);
    chk("R2 valid one cycle", 32'(blk_valid), 0);
    rd(8'h1C, r); chk("R6 drdy low while busy", r & 32'h1, 0);
    idle(LAT + 4);
    for (int n = 0; n < 8; n++) begin
      rd(8'h80 + 8'(4*n), r);
      chk("R5 sha1 digest", r, (n < 5) ? exp_dig(n, cur[n], 1'b1, 1'b0) : 32'h0);
    end
    rd(8'h1C, r); chk("R6 drdy set after done", r, 32'h1);
    chk("R8 irq masked off", 32'(irq), 0);

    // R2 start while busy ignored; R4 no first
    base = launches;
    wr(8'h00, 32'h1);
    chk("R4 chained block not first", 32'(blk_first), 0);
    wr(8'h00, 32'h1);
    idle(LAT + 4);
    chk("R2 start while busy ignored", 32'(launches), 32'(base + 1));

    // R7 mask set/clear, R8 irq sweep (status = drdy only)
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h18, r); chk("R7 mask implemented bits", r, 32'h107);
    wr(8'h14, 32'h6);
    rd(8'h18, r); chk("R7 mask clear", r, 32'h101);
    for (int c = 0; c < 16; c++) begin
      logic [31:0] m;
      m = (c[0] ? 32'h1 : 0) | (c[1] ? 32'h2 : 0) | (c[2] ? 32'h4 : 0) | (c[3] ? 32'h100 : 0);
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h10, m);
      rd(8'h18, r); chk("R7 mask readback", r, m);
      chk("R8 irq", 32'(irq), 32'(c[0]));
    end
    wr(8'h14, 32'hFFFF_FFFF);

    // R3 auto feed, SHA-256, R12 readback
    wr(8'h04, 32'h101);
    rd(8'h04, r); chk("R12 mode readback", r, 32'h101);
    base = launches;
    wr(8'h00, 32'h10);
    idle(1);
    chk("R4 first arm does not launch", 32'(launches), 32'(base));
    for (int n = 0; n < 16; n++) begin
      cur[n] = ~(32'h0300_0000 + 32'(n) * 32'h0011_2233);
      wr_word(n, cur[n]);
      if (n < 15) chk("R3 no launch before last word", 32'(launches + (blk_valid ? 1 : 0)), 32'(base));
    end
    chk("R3 launch on last word", 32'(blk_valid), 1);
    chk("R4 armed first", 32'(blk_first), 1);
    chk("R2 algo sha256", 32'(algo), 1);
    rd(8'h1C, r); chk("R6 drdy cleared by launch", r & 32'h1, 0);
    idle(LAT + 4);
    for (int n = 0; n < 8; n++) begin
      rd(8'h80 + 8'(4*n), r);
      chk("R5 sha256 digest", r, exp_dig(n, cur[n], 1'b1, 1'b1));
    end

    // R4 chained auto block
    for (int n = 0; n < 16; n++) begin
      cur[n] = 32'h5A00_0000 ^ (32'(n) << 4);
      wr_word(n, cur[n]);
    end
    chk("R4 chained auto not first", 32'(blk_first), 0);
    idle(LAT + 4);
    rd(8'h84, r); chk("R5 chained digest", r, exp_dig(1, cur[1], 1'b0, 1'b1));

    // R9 violations while busy (manual)
    wr(8'h04, 32'h0);
    rd(8'h1C, r);
    wr(8'h00, 32'h1);
    wr_word(3, 32'hDEAD_BEEF);
    wr(8'h04, 32'h101);
    rd(8'h1C, r); chk("R9 din write code held", r & 32'h7100, 32'h0100);
    rd(8'h1C, r); chk("R9 cleared by status read", r & 32'h7100, 32'h0);
    wr(8'h04, 32'h101);
    rd(8'h1C, r); chk("R9 mode write code", r & 32'h7100, 32'h2100);
    rd(8'h80, r);
    rd(8'h1C, r); chk("R9 digest read code", r & 32'h7100, 32'h1100);
    idle(LAT + 4);
    rd(8'h04, r); chk("R9 mode write dropped", r, 32'h0);
    wr(8'h00, 32'h1);
    chk("R9 din write dropped", blk_data[32*3 +: 32], cur[3]);
    idle(LAT + 4);
    wr(8'h1C, 32'h0);
    rd(8'h1C, r); chk("R9 status write code", r & 32'h7100, 32'h5100);
    wr(8'h84, 32'h0);
    rd(8'h1C, r); chk("R9 digest write code", r & 32'h7100, 32'h5100);
    wr(8'h18, 32'h0);
    rd(8'h1C, r); chk("R9 mask write code", r & 32'h7100, 32'h5100);

    // R10 DMA feed
    wr(8'h04, 32'h2);
    base = launches;
    for (int n = 0; n < 16; n++) wr_word(n, 32'h7700_0000 + 32'(n));
    chk("R3 dma launch on last word", 32'(blk_valid), 1);
    rd(8'h1C, r); chk("R10 txe set on dma launch", r & 32'h4, 32'h4);
    idle(LAT + 4);
    rd(8'h1C, r); chk("R10 txe held", r & 32'h5, 32'h5);
    wr_word(0, 32'h1);
    rd(8'h1C, r); chk("R10 txe cleared by word write", r & 32'h4, 32'h0);

    // R11 software reset, R12 spare bits
    wr(8'h04, 32'hFFFF_FFF8);
    rd(8'h04, r); chk("R12 mode spare bits", r, 32'h118);
    wr(8'h10, 32'h107);
    chk("R8 irq with drdy", 32'(irq), 1);
    wr(8'h00, 32'h10);
    wr(8'h00, 32'h100);
    rd(8'h04, r); chk("R11 mode cleared", r, 0);
    rd(8'h18, r); chk("R11 mask cleared", r, 0);
    rd(8'h1C, r); chk("R11 status cleared", r, 0);
    rd(8'h80, r); chk("R11 digest cleared", r, 0);
    chk("R11 irq low", 32'(irq), 0);
    chk("R11 block cleared", blk_data[31:0], 0);
    wr(8'h00, 32'h1);
    chk("R11 pending first cleared", 32'(blk_first), 0);
    idle(LAT + 4);

    finished = 1;
    report();
  end
endmodule